// File: doc/BRIEF.md
# Command Packet Slot Restriction Checker

This block watches a memory channel's request stream one cycle at a time. In each cycle there may be one row packet and one column packet. Each packet names a target device, and a row packet also carries a broadcast flag. The block does not change the stream. It only reports placements that break the rules that apply while one device moves to a lower power state. It also reports packets that the sleeping device will silently drop.

There are two kinds of marker, and each arrives together with the row packet that starts the transition. A standby marker opens a frame window of `frame_len` cycles. During that window the late column slots are forbidden to every device, and the earlier slots are forbidden only to the target device. A low-power entry marker opens two windows. The restricted window forbids traffic aimed at the target device. The quiet window forbids broadcast row packets. Once the restricted window closes, later traffic to that device is reported as ignored instead of as a violation.

Offsets count cycles from the marker cycle, which is offset 0. The window lengths are sampled in the marker cycle. Each flagged cycle gives a single-cycle pulse, one clock later, together with a rule code.

Top module: `pkt_slot_checker`

## Requirements
- R1: After a standby marker with frame length F, a column packet to any device at offset k with F-3 <= k <= F-1 and k >= 1 gives `viol` with code 3.
- R2: After a standby marker, a column packet to the marked device at offsets 1 to F-4 gives code 4. At offset F or later it gives no flag.
- R3: A column packet to a device other than the marked one gives no flag at offsets up to F-4, and none at offset F or later.
- R4: After a low-power entry marker with restricted length L, a non-broadcast row packet or a column packet to the marked device at offsets 1 to L gives code 1.
- R5: Row or column packets to other devices at offsets 1 to L give no flag.
- R6: After a low-power entry marker with quiet length Q, a broadcast row packet at offsets 1 to Q gives code 2. At offset Q+1 or later it gives no flag.
- R7: After the restricted window, a non-broadcast row packet or a column packet to the marked device gives an `ignore` pulse and no violation. This lasts until the next entry marker. Packets to other devices give nothing.
- R8: `viol` and `ignore` rise exactly one cycle after the offending packet cycle and last one cycle per offending cycle. `viol_code` is 0 whenever `viol` is low. `viol` and `ignore` are never high together, and a violation wins over an ignore.
- R9: When several rules hit in the same cycle, the reported code follows the priority 1, then 2, then 3, then 4.
- R10: A new marker restarts its window from its own cycle. Packets in the marker cycle are judged against the state that held before it. Lengths are captured at the marker, so later changes on the length inputs have no effect on an open window.
- R11: During and right after reset, `viol`, `viol_code` and `ignore` are 0 and no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_vld | input | 1 | A row packet is present this cycle |
| row_dev | input | DEV_W | Target device of the row packet |
| row_bcast | input | 1 | The row packet is a broadcast |
| col_vld | input | 1 | A column packet is present this cycle |
| col_dev | input | DEV_W | Target device of the column packet |
| stby_start | input | 1 | This cycle's row packet starts a standby transition for row_dev |
| lp_entry | input | 1 | This cycle's row packet is a low-power entry for row_dev |
| frame_len | input | CNT_W | Frame length F in cycles, sampled at stby_start |
| restr_len | input | CNT_W | Restricted window length L, sampled at lp_entry |
| quiet_len | input | CNT_W | Quiet window length Q, sampled at lp_entry |
| viol | output | 1 | Violation pulse |
| viol_code | output | 3 | Rule code: 1 restricted, 2 quiet, 3 frame slot, 4 early same device |
| ignore | output | 1 | Packet will be dropped by the sleeping device |

## Verification
If a window counter is off by one, a packet placed at the first or last offset of a window is misjudged. That shows up as a missing or extra pulse one clock after that packet. For this reason the bench places packets exactly on window edges: F-4, F-3, F-1, F, L, L+1, Q and Q+1. If the captured device or length is stale, the error only appears once a second marker is issued or the length inputs are changed mid-window. If the priority order is wrong, the code differs in cycles where two rules collide, even though `viol` itself looks right.

// File: rtl/slotchk_pkg.sv
package slotchk_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        VC_NONE       = 3'd0,
        VC_RESTRICT   = 3'd1,
        VC_QUIET      = 3'd2,
        VC_FRAME_SLOT = 3'd3,
        VC_EARLY_SAME = 3'd4
    } viol_code_e;

    typedef struct packed {
        logic restrict_hit;
        logic quiet_hit;
        logic slot_hit;
        logic early_hit;
        logic ignore_hit;
    } rule_hits_t;

    // Highest-priority broken rule in one cycle.
    function automatic viol_code_e pick_code(input rule_hits_t h);
        if (h.restrict_hit)   return VC_RESTRICT;
        else if (h.quiet_hit) return VC_QUIET;
        else if (h.slot_hit)  return VC_FRAME_SLOT;
        else if (h.early_hit) return VC_EARLY_SAME;
        else                  return VC_NONE;
    endfunction

endpackage

// File: rtl/stby_window.sv
module stby_window #(
    parameter int DEV_W = 5,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DEV_W-1:0] start_dev,
    input  logic [CNT_W-1:0] frame_len,
    input  logic             col_vld,
    input  logic [DEV_W-1:0] col_dev,
    output logic             slot_hit,
    output logic             early_hit
);
    localparam int EXT_W = CNT_W + 1;

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;
    logic [DEV_W-1:0] dev_q;

    logic [EXT_W-1:0] cnt_plus3;
    logic [EXT_W-1:0] cnt_plus1;
    logic             in_late_zone;
    logic             same_dev;

    assign cnt_plus3    = {1'b0, cnt_q} + EXT_W'(3);
    assign cnt_plus1    = {1'b0, cnt_q} + EXT_W'(1);
    assign in_late_zone = active_q && (cnt_plus3 >= {1'b0, len_q});
    assign same_dev     = (col_dev == dev_q);

    assign slot_hit  = col_vld && in_late_zone;
    assign early_hit = col_vld && active_q && !in_late_zone && same_dev;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            len_q    <= '0;
            dev_q    <= '0;
        end else if (start) begin
            dev_q    <= start_dev;
            len_q    <= frame_len;
            cnt_q    <= CNT_W'(1);
            active_q <= (frame_len > CNT_W'(1));
        end else if (active_q) begin
            cnt_q <= cnt_plus1[CNT_W-1:0];
            if (cnt_plus1 >= {1'b0, len_q}) begin
                active_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lp_window.sv
module lp_window #(
    parameter int DEV_W = 5,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DEV_W-1:0] start_dev,
    input  logic [CNT_W-1:0] restr_len,
    input  logic [CNT_W-1:0] quiet_len,
    input  logic             row_vld,
    input  logic [DEV_W-1:0] row_dev,
    input  logic             row_bcast,
    input  logic             col_vld,
    input  logic [DEV_W-1:0] col_dev,
    output logic             restrict_hit,
    output logic             quiet_hit,
    output logic             ignore_hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             on_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rlen_q;
    logic [CNT_W-1:0] qlen_q;
    logic [DEV_W-1:0] dev_q;

    logic in_restrict;
    logic in_quiet;
    logic asleep;
    logic aimed_at_dev;

    assign in_restrict  = on_q && (cnt_q <= rlen_q);
    assign in_quiet     = on_q && (cnt_q <= qlen_q);
    assign asleep       = on_q && (cnt_q > rlen_q);
    assign aimed_at_dev = (row_vld && !row_bcast && (row_dev == dev_q)) ||
                          (col_vld && (col_dev == dev_q));

    assign restrict_hit = in_restrict && aimed_at_dev;
    assign quiet_hit    = in_quiet && row_vld && row_bcast;
    assign ignore_hit   = asleep && aimed_at_dev;

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q   <= 1'b0;
            cnt_q  <= '0;
            rlen_q <= '0;
            qlen_q <= '0;
            dev_q  <= '0;
        end else if (start) begin
            on_q   <= 1'b1;
            cnt_q  <= CNT_W'(1);
            rlen_q <= restr_len;
            qlen_q <= quiet_len;
            dev_q  <= start_dev;
        end else if (on_q && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/slot_verdict.sv
module slot_verdict
    import slotchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rule_hits_t        hits,
    output logic              viol,
    output logic [CODE_W-1:0] viol_code,
    output logic              ignore
);
    viol_code_e code_d;
    logic       viol_d;
    logic       ign_d;

    assign code_d = pick_code(hits);
    assign viol_d = (code_d != VC_NONE);
    assign ign_d  = hits.ignore_hit && !viol_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            viol      <= 1'b0;
            viol_code <= '0;
            ignore    <= 1'b0;
        end else begin
            viol      <= viol_d;
            viol_code <= code_d;
            ignore    <= ign_d;
        end
    end

endmodule

// File: rtl/pkt_slot_checker.sv
module pkt_slot_checker
    import slotchk_pkg::*;
#(
    parameter int DEV_W = 5,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              row_vld,
    input  logic [DEV_W-1:0]  row_dev,
    input  logic              row_bcast,
    input  logic              col_vld,
    input  logic [DEV_W-1:0]  col_dev,
    input  logic              stby_start,
    input  logic              lp_entry,
    input  logic [CNT_W-1:0]  frame_len,
    input  logic [CNT_W-1:0]  restr_len,
    input  logic [CNT_W-1:0]  quiet_len,
    output logic              viol,
    output logic [CODE_W-1:0] viol_code,
    output logic              ignore
);
    rule_hits_t hits;

    stby_window #(.DEV_W(DEV_W), .CNT_W(CNT_W)) stby_i (
        .clk       (clk),
        .rst       (rst),
        .start     (stby_start && row_vld),
        .start_dev (row_dev),
        .frame_len (frame_len),
        .col_vld   (col_vld),
        .col_dev   (col_dev),
        .slot_hit  (hits.slot_hit),
        .early_hit (hits.early_hit)
    );

    lp_window #(.DEV_W(DEV_W), .CNT_W(CNT_W)) lp_i (
        .clk          (clk),
        .rst          (rst),
        .start        (lp_entry && row_vld),
        .start_dev    (row_dev),
        .restr_len    (restr_len),
        .quiet_len    (quiet_len),
        .row_vld      (row_vld),
        .row_dev      (row_dev),
        .row_bcast    (row_bcast),
        .col_vld      (col_vld),
        .col_dev      (col_dev),
        .restrict_hit (hits.restrict_hit),
        .quiet_hit    (hits.quiet_hit),
        .ignore_hit   (hits.ignore_hit)
    );

    slot_verdict verdict_i (
        .clk       (clk),
        .rst       (rst),
        .hits      (hits),
        .viol      (viol),
        .viol_code (viol_code),
        .ignore    (ignore)
    );

endmodule

// File: rtl/pkt_slot_checker_sva.sv
module pkt_slot_checker_sva (
    input logic       clk,
    input logic       rst,
    input logic       row_vld,
    input logic       row_bcast,
    input logic       col_vld,
    input logic       viol,
    input logic [2:0] viol_code,
    input logic       ignore
);

    AST_CODE_WITH_VIOL: assert property (@(posedge clk) disable iff (rst)
        viol |-> (viol_code != 3'd0)); // R8

    AST_CODE_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !viol |-> (viol_code == 3'd0)); // R8

    AST_VIOL_IGN_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(viol && ignore)); // R8

    AST_VIOL_FROM_PKT: assert property (@(posedge clk) disable iff (rst)
        viol |-> $past(row_vld || col_vld)); // R8

    AST_SLOT_FROM_COL: assert property (@(posedge clk) disable iff (rst)
        (viol && viol_code == 3'd3) |-> $past(col_vld)); // R1

    AST_EARLY_FROM_COL: assert property (@(posedge clk) disable iff (rst)
        (viol && viol_code == 3'd4) |-> $past(col_vld)); // R2

    AST_QUIET_FROM_BCAST: assert property (@(posedge clk) disable iff (rst)
        (viol && viol_code == 3'd2) |-> $past(row_vld && row_bcast)); // R6

    AST_IGN_FROM_PKT: assert property (@(posedge clk) disable iff (rst)
        ignore |-> $past(row_vld || col_vld)); // R7

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        viol_code <= 3'd4); // R9

endmodule

bind pkt_slot_checker pkt_slot_checker_sva sva_i (
    .clk       (clk),
    .rst       (rst),
    .row_vld   (row_vld),
    .row_bcast (row_bcast),
    .col_vld   (col_vld),
    .viol      (viol),
    .viol_code (viol_code),
    .ignore    (ignore)
);

// File: tb/pkt_slot_checker_tb_top.sv
module pkt_slot_checker_tb_top;

    localparam int DEV_W = 5;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             row_vld = 1'b0;
    logic [DEV_W-1:0] row_dev = '0;
    logic             row_bcast = 1'b0;
    logic             col_vld = 1'b0;
    logic [DEV_W-1:0] col_dev = '0;
    logic             stby_start = 1'b0;
    logic             lp_entry = 1'b0;
    logic [CNT_W-1:0] frame_len = 8'd8;
    logic [CNT_W-1:0] restr_len = 8'd4;
    logic [CNT_W-1:0] quiet_len = 8'd6;
    logic             viol;
    logic [2:0]       viol_code;
    logic             ignore;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    pkt_slot_checker #(.DEV_W(DEV_W), .CNT_W(CNT_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .row_vld    (row_vld),
        .row_dev    (row_dev),
        .row_bcast  (row_bcast),
        .col_vld    (col_vld),
        .col_dev    (col_dev),
        .stby_start (stby_start),
        .lp_entry   (lp_entry),
        .frame_len  (frame_len),
        .restr_len  (restr_len),
        .quiet_len  (quiet_len),
        .viol       (viol),
        .viol_code  (viol_code),
        .ignore     (ignore)
    );

    // One cycle of stimulus; outputs for it are sampled after the next edge.
    task automatic step(input logic rv, input logic [DEV_W-1:0] rd, input logic rb,
                        input logic cv, input logic [DEV_W-1:0] cd,
                        input logic sb, input logic lp);
        @(negedge clk);
        row_vld = rv; row_dev = rd; row_bcast = rb;
        col_vld = cv; col_dev = cd; stby_start = sb; lp_entry = lp;
        @(posedge clk);
        #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0, '0, 0, 0);
    endtask

    task automatic expect_out(input logic ev, input logic [2:0] ec, input logic ei,
                              input string tag);
        checks++;
        if (viol !== ev || viol_code !== ec || ignore !== ei) begin
            errors++;
            $display("FAIL %s: got viol=%b code=%0d ign=%b, expected viol=%b code=%0d ign=%b",
                     tag, viol, viol_code, ignore, ev, ec, ei);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        expect_out(0, 3'd0, 0, "R11 in reset");
        @(negedge clk);
        rst = 1'b0;
        step(0, '0, 0, 1, 5'd2, 0, 0);
        expect_out(0, 3'd0, 0, "R11 no window after reset");
    endtask

    task automatic t_stby_other;
        frame_len = 8'd8;
        step(1, 5'd2, 0, 0, '0, 1, 0);
        expect_out(0, 3'd0, 0, "R10 marker cycle clean");
        frame_len = 8'd20;               // must not affect open window (R10)
        idle(3);
        step(0, '0, 0, 1, 5'd5, 0, 0);   // offset 4 = F-4
        expect_out(0, 3'd0, 0, "R3 other dev at F-4");
        step(0, '0, 0, 1, 5'd5, 0, 0);   // offset 5 = F-3
        expect_out(1, 3'd3, 0, "R1 other dev at F-3");
        idle(1);
        step(0, '0, 0, 1, 5'd5, 0, 0);   // offset 7 = F-1
        expect_out(1, 3'd3, 0, "R1 other dev at F-1 (R10 length captured)");
        step(0, '0, 0, 1, 5'd5, 0, 0);   // offset 8 = F
        expect_out(0, 3'd0, 0, "R3 other dev at F");
    endtask

    task automatic t_stby_same;
        frame_len = 8'd8;
        step(1, 5'd2, 0, 0, '0, 1, 0);
        step(0, '0, 0, 1, 5'd2, 0, 0);   // offset 1
        expect_out(1, 3'd4, 0, "R2 same dev at offset 1");
        idle(2);
        step(0, '0, 0, 1, 5'd2, 0, 0);   // offset 4
        expect_out(1, 3'd4, 0, "R2 same dev at F-4");
        idle(1);
        step(0, '0, 0, 1, 5'd2, 0, 0);   // offset 6
        expect_out(1, 3'd3, 0, "R1 same dev in late slot");
        idle(1);
        step(0, '0, 0, 1, 5'd2, 0, 0);   // offset 8
        expect_out(0, 3'd0, 0, "R2 same dev at F");
    endtask

    task automatic t_stby_short;
        frame_len = 8'd3;
        step(1, 5'd2, 0, 0, '0, 1, 0);
        step(0, '0, 0, 1, 5'd9, 0, 0);   // offset 1 = F-2
        expect_out(1, 3'd3, 0, "R1 short frame offset 1");
        idle(1);
        step(0, '0, 0, 1, 5'd9, 0, 0);   // offset 3 = F
        expect_out(0, 3'd0, 0, "R3 short frame at F");
    endtask

    task automatic t_lp_windows;
        restr_len = 8'd4; quiet_len = 8'd6;
        step(1, 5'd1, 0, 0, '0, 0, 1);
        expect_out(0, 3'd0, 0, "R10 entry marker clean");
        step(0, '0, 0, 1, 5'd1, 0, 0);   // offset 1
        expect_out(1, 3'd1, 0, "R4 col to d0 restricted");
        step(1, 5'd3, 0, 1, 5'd4, 0, 0); // offset 2
        expect_out(0, 3'd0, 0, "R5 other devs in restricted");
        step(1, 5'd3, 1, 0, '0, 0, 0);   // offset 3
        expect_out(1, 3'd2, 0, "R6 broadcast in quiet");
        step(1, 5'd1, 0, 0, '0, 0, 0);   // offset 4 = L
        expect_out(1, 3'd1, 0, "R4 row to d0 at L");
        step(0, '0, 0, 1, 5'd1, 0, 0);   // offset 5 = L+1
        expect_out(0, 3'd0, 1, "R7 col to d0 after restricted");
        step(1, 5'd0, 1, 0, '0, 0, 0);   // offset 6 = Q
        expect_out(1, 3'd2, 0, "R6 broadcast at Q");
        step(1, 5'd0, 1, 0, '0, 0, 0);   // offset 7 = Q+1
        expect_out(0, 3'd0, 0, "R6 broadcast after Q");
        step(0, '0, 0, 1, 5'd1, 0, 0);   // offset 8
        expect_out(0, 3'd0, 1, "R7 d0 still ignoring");
        step(0, '0, 0, 1, 5'd0, 0, 0);   // offset 9
        expect_out(0, 3'd0, 0, "R7 other dev not ignored");
    endtask

    task automatic t_priority;
        frame_len = 8'd8; restr_len = 8'd4; quiet_len = 8'd6;
        step(1, 5'd6, 0, 0, '0, 1, 1);
        expect_out(0, 3'd0, 0, "R9 dual marker clean");
        idle(1);
        step(0, '0, 0, 1, 5'd6, 0, 0);   // offset 2
        expect_out(1, 3'd1, 0, "R9 restricted over early");
        idle(3);
        step(1, 5'd0, 1, 1, 5'd7, 0, 0); // offset 6
        expect_out(1, 3'd2, 0, "R9 quiet over slot");
        step(0, '0, 0, 1, 5'd6, 0, 0);   // offset 7
        expect_out(1, 3'd3, 0, "R8 violation wins over ignore");
    endtask

    task automatic t_restart;
        restr_len = 8'd2; quiet_len = 8'd0;
        step(1, 5'd1, 0, 0, '0, 0, 1);
        idle(2);
        step(0, '0, 0, 1, 5'd1, 0, 0);   // offset 3
        expect_out(0, 3'd0, 1, "R7 ignore after short window");
        restr_len = 8'd5;
        step(1, 5'd1, 0, 0, '0, 0, 1);
        expect_out(0, 3'd0, 1, "R10 marker judged by old state");
        restr_len = 8'd0;
        idle(2);
        step(0, '0, 0, 1, 5'd1, 0, 0);   // offset 3
        expect_out(1, 3'd1, 0, "R10 restarted window, length captured");
    endtask

    initial begin
        t_reset();
        t_stby_other();
        t_stby_same();
        t_stby_short();
        t_lp_windows();
        t_priority();
        t_restart();
        idle(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule